// File: doc/BRIEF.md
# Iterative Feistel Block Cipher Engine

This block encrypts or decrypts one 64-bit block through a 16-round Feistel network. One 64-bit state register circulates through a single shared round datapath. The datapath holds one round-function instance, four 256 x 32-bit substitution tables and an 18 x 32-bit subkey array. Each of these five memories has exactly one registered read port, so every round spans two clock cycles. The first cycle XORs the left half with its subkey and issues the table reads. The second cycle combines the table words and updates the halves.

The tables and the subkey array are loaded from outside through a single write port, so the engine is keyed by whatever contents are written. No key expansion takes place inside the block. A caller waits for `ready_o`, pulses `new_data_i` with the block and the direction, then waits for `ready_o` to return. When it does, `data_o` holds the result.

Top module: `fstl_cipher_engine`

## Requirements
- R1: While `rst_ni` is low and after its release, `ready_o` is 1 and `data_o` is 0 until the first block completes.
- R2: With `encrypt_i`=1 at acceptance, the left half is `data_i[63:32]` and the right half is `data_i[31:0]`. Each round k=0..15 does three steps in order: left ^= P[k], then right ^= F(left), then the halves swap. After round 15 the swap is undone, right ^= P[16] and left ^= P[17]. `data_o` is {left, right}.
- R3: With `encrypt_i`=0 at acceptance, the same sequence runs with subkey P[17-k] in place of P[k]. Decrypting a ciphertext therefore returns the original plaintext.
- R4: F splits its 32-bit input into bytes a (bits 31:24), b, c and d (bits 7:0) and returns ((S0[a] + S1[b]) XOR S2[c]) + S3[d], with both sums taken modulo 2^32.
- R5: `ready_o` goes low on the clock edge that accepts `new_data_i` and goes high again exactly 37 clock edges later.
- R6: `new_data_i` is accepted only while `ready_o` is 1. While `ready_o` is 0, pulses on `new_data_i` and changes on `data_i` and `encrypt_i` have no effect on the running block or on the state after it.
- R7: `data_o` changes only on the edge where `ready_o` rises, and it holds its value at every other time.
- R8: A write with `tbl_we_i`=1 stores `tbl_wdata_i` at address `tbl_addr_i` of the memory chosen by `tbl_sel_i`. Values 0 to 3 choose S0 to S3, and 4 chooses the subkey array, where only addresses 0 to 17 are stored. Writes are ignored while `ready_o` is 0, for any other `tbl_sel_i` value, and to subkey addresses above 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_sel_i | input | 3 | Target memory: 0-3 substitution tables, 4 subkey array |
| tbl_addr_i | input | 8 | Write address |
| tbl_wdata_i | input | 32 | Write data |
| new_data_i | input | 1 | Start a block operation (taken only while ready_o is 1) |
| encrypt_i | input | 1 | 1 encrypt, 0 decrypt; sampled at acceptance |
| data_i | input | 64 | Input block, left half in the upper 32 bits |
| ready_o | output | 1 | Idle and able to accept; result valid after an operation |
| data_o | output | 64 | Result block |

## Verification
The assertions check the 37-edge spacing between acceptance and the return of `ready_o` (R5) on every cycle. They also check that an accepted start always drops `ready_o` (R6) and that `data_o` holds everywhere except the rising edge of `ready_o` (R7). Correct ciphertext and plaintext (R2, R3, R4) can only be shown by the bench's scenarios, which compare against an independent model filled with the same table contents. Those scenarios also cover starts and table writes that must be ignored while busy, and the masking of out-of-range subkey addresses (R6, R8).

// File: rtl/fstl_pkg.sv
package fstl_pkg;
  localparam int unsigned ROUNDS  = 16;
  localparam int unsigned NSUB    = ROUNDS + 2;
  localparam int unsigned SUB_AW  = $clog2(NSUB);
  localparam int unsigned RND_W   = $clog2(ROUNDS);
  localparam int unsigned NUM_SB  = 4;
  localparam int unsigned LATENCY = 2 * ROUNDS + 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_RND_A, ST_RND_B, ST_FIN_A, ST_FIN_B, ST_FIN_C, ST_WRBK
  } eng_state_e;
endpackage

// File: rtl/fstl_tbl_mem.sv
module fstl_tbl_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (32'(waddr_i) < DEPTH)) mem_q[waddr_i] <= wdata_i;
  end

  // registered read, holds between reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              rdata_o <= '0;
    else if (re_i && (32'(raddr_i) < DEPTH))  rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/fstl_round_fn.sv
module fstl_round_fn #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NUM_SB = 4,
  localparam int unsigned WW    = NUM_SB * BYTE_W
) (
  input  logic [NUM_SB-1:0][WW-1:0] s_i,
  output logic [WW-1:0]             f_o
);
  logic [WW-1:0] sum01;
  assign sum01 = s_i[0] + s_i[1];
  assign f_o   = (sum01 ^ s_i[2]) + s_i[3];
endmodule

// File: rtl/fstl_cipher_engine.sv
module fstl_cipher_engine
  import fstl_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned HALF_W = NUM_SB * BYTE_W,
  localparam int unsigned BLK_W  = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [SEL_W-1:0]  tbl_sel_i,
  input  logic [BYTE_W-1:0] tbl_addr_i,
  input  logic [HALF_W-1:0] tbl_wdata_i,
  input  logic              new_data_i,
  input  logic              encrypt_i,
  input  logic [BLK_W-1:0]  data_i,
  output logic              ready_o,
  output logic [BLK_W-1:0]  data_o
);
  localparam int unsigned SB_DEPTH = 2 ** BYTE_W;

  eng_state_e         state_q;
  logic [RND_W-1:0]   rnd_q;
  logic [SUB_AW-1:0]  kidx_q;
  logic               enc_q;
  logic [HALF_W-1:0]  l_q, r_q;
  logic [BLK_W-1:0]   dout_q;
  logic               rdy_q;

  logic                           wr_ok, accept, last_rnd;
  logic                           pk_re, pk_we, sb_re;
  logic [SUB_AW-1:0]              pk_raddr;
  logic [HALF_W-1:0]              pk_rdata, xl, f_val;
  logic [NUM_SB-1:0][HALF_W-1:0]  sb_rdata;

  assign wr_ok    = tbl_we_i & rdy_q;
  assign accept   = new_data_i & rdy_q & (state_q == ST_IDLE);
  assign last_rnd = (rnd_q == RND_W'(ROUNDS - 1));

  // subkey walk: forward for encrypt, reversed for decrypt
  assign pk_re    = (state_q == ST_LOAD) | ((state_q == ST_RND_A) & ~last_rnd) |
                    (state_q == ST_FIN_A) | (state_q == ST_FIN_B);
  assign pk_raddr = enc_q ? kidx_q : SUB_AW'(NSUB - 1) - kidx_q;
  assign pk_we    = wr_ok & (tbl_sel_i == SEL_W'(NUM_SB)) & (32'(tbl_addr_i) < NSUB);
  assign xl       = l_q ^ pk_rdata;
  assign sb_re    = (state_q == ST_RND_A);

  fstl_tbl_mem #(.DEPTH(NSUB), .AW(SUB_AW), .DW(HALF_W)) u_pk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pk_we),
    .waddr_i (tbl_addr_i[SUB_AW-1:0]),
    .wdata_i (tbl_wdata_i),
    .re_i    (pk_re),
    .raddr_i (pk_raddr),
    .rdata_o (pk_rdata)
  );

  for (genvar g = 0; g < NUM_SB; g++) begin : g_sb
    logic sb_we;
    assign sb_we = wr_ok & (tbl_sel_i == SEL_W'(g));
    // table g is addressed by byte g counted from the top
    fstl_tbl_mem #(.DEPTH(SB_DEPTH), .AW(BYTE_W), .DW(HALF_W)) u_sb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (sb_we),
      .waddr_i (tbl_addr_i),
      .wdata_i (tbl_wdata_i),
      .re_i    (sb_re),
      .raddr_i (xl[HALF_W-1-g*BYTE_W -: BYTE_W]),
      .rdata_o (sb_rdata[g])
    );
  end

  fstl_round_fn #(.BYTE_W(BYTE_W), .NUM_SB(NUM_SB)) u_f (
    .s_i (sb_rdata),
    .f_o (f_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rnd_q   <= '0;
      kidx_q  <= '0;
      enc_q   <= 1'b1;
      l_q     <= '0;
      r_q     <= '0;
      dout_q  <= '0;
      rdy_q   <= 1'b1;
    end else begin
      if (pk_re) kidx_q <= kidx_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          l_q     <= data_i[BLK_W-1:HALF_W];
          r_q     <= data_i[HALF_W-1:0];
          enc_q   <= encrypt_i;
          kidx_q  <= '0;
          rnd_q   <= '0;
          rdy_q   <= 1'b0;
          state_q <= ST_LOAD;
        end
        ST_LOAD:  state_q <= ST_RND_A;
        ST_RND_A: begin
          l_q     <= xl;
          state_q <= ST_RND_B;
        end
        ST_RND_B: begin
          l_q     <= r_q ^ f_val;
          r_q     <= l_q;
          rnd_q   <= rnd_q + 1'b1;
          state_q <= last_rnd ? ST_FIN_A : ST_RND_A;
        end
        ST_FIN_A: state_q <= ST_FIN_B;
        // after the last swap l_q holds the right half and r_q the left
        ST_FIN_B: begin
          l_q     <= l_q ^ pk_rdata;
          state_q <= ST_FIN_C;
        end
        ST_FIN_C: begin
          r_q     <= r_q ^ pk_rdata;
          state_q <= ST_WRBK;
        end
        ST_WRBK: begin
          dout_q  <= {r_q, l_q};
          rdy_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = rdy_q;
  assign data_o  = dout_q;

  // latency counter for checking only
  logic [5:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (accept) lat_q <= '0;
    else if (!rdy_q) lat_q <= lat_q + 1'b1;
  end

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (lat_q == 6'(LATENCY)));

  p_ready_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (state_q == ST_IDLE));

  p_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && new_data_i) |=> !ready_o);

  p_dout_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(ready_o) |-> $stable(data_o));
endmodule

// File: tb/sim_fstl_cipher_engine.sv
module sim_fstl_cipher_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_sel = '0;
  logic [7:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic        new_data = 1'b0;
  logic        encrypt = 1'b1;
  logic [63:0] data_in = '0;
  logic        ready;
  logic [63:0] data_out;

  always #2 clk = ~clk;

  fstl_cipher_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .tbl_we_i(tbl_we), .tbl_sel_i(tbl_sel),
    .tbl_addr_i(tbl_addr), .tbl_wdata_i(tbl_wdata), .new_data_i(new_data),
    .encrypt_i(encrypt), .data_i(data_in), .ready_o(ready), .data_o(data_out)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] sb_m [4][256];
  logic [31:0] pk_m [18];

  typedef struct { logic [63:0] exp; int tag; } item_t;
  item_t exp_q [$];

  function automatic string tag_name(int t);
    case (t)
      3: return "R3";
      6: return "R6";
      8: return "R8";
      default: return "R2 R4";
    endcase
  endfunction

  function automatic logic [31:0] mixv(int s);
    logic [31:0] v;
    v = 32'(s) * 32'h9E3779B1;
    v = v ^ (v >> 15);
    v = v * 32'h85EBCA6B;
    return v ^ (v >> 13);
  endfunction

  function automatic logic [31:0] f_model(logic [31:0] x);
    return ((sb_m[0][x[31:24]] + sb_m[1][x[23:16]]) ^ sb_m[2][x[15:8]]) + sb_m[3][x[7:0]];
  endfunction

  function automatic logic [63:0] model(logic [63:0] d, bit enc);
    logic [31:0] l, r, t;
    l = d[63:32]; r = d[31:0];
    for (int k = 0; k < 16; k++) begin
      l = l ^ pk_m[enc ? k : 17 - k];
      r = r ^ f_model(l);
      t = l; l = r; r = t;
    end
    t = l; l = r; r = t;
    r = r ^ pk_m[enc ? 16 : 1];
    l = l ^ pk_m[enc ? 17 : 0];
    return {l, r};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic tbl_write(int sel, int addr, logic [31:0] v);
    tbl_we = 1'b1; tbl_sel = 3'(sel); tbl_addr = 8'(addr); tbl_wdata = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // driver: push expected, then pulse the start
  task automatic run_op(logic [63:0] pt, bit enc, int tag, logic [63:0] expv);
    while (!ready) @(negedge clk);
    exp_q.push_back('{exp: expv, tag: tag});
    data_in = pt; encrypt = enc; new_data = 1'b1;
    @(negedge clk);
    new_data = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (exp_q.size() != 0 || !ready) @(negedge clk);
  endtask

  // monitor: latency, hold and result per completed block
  int busy_cnt = 0;
  bit hold_bad = 0;
  logic [63:0] last_out = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      busy_cnt = 0; hold_bad = 0; last_out = data_out;
    end else if (!ready) begin
      busy_cnt++;
      if (data_out !== last_out) hold_bad = 1;
    end else begin
      if (busy_cnt > 0) begin
        item_t it;
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R6: unexpected completion actual %h expected none", data_out);
        end else begin
          it = exp_q.pop_front();
          check(data_out === it.exp, tag_name(it.tag), data_out, it.exp);
        end
        check(busy_cnt == 37, "R5 latency", 64'(busy_cnt), 64'd37);
        check(!hold_bad, "R7 hold", 64'(hold_bad), 64'd0);
        busy_cnt = 0; hold_bad = 0;
      end
      last_out = data_out;
    end
  end

  bit fin = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] ct, pt;
    repeat (3) @(negedge clk);
    check(ready === 1'b1, "R1 ready in reset", 64'(ready), 64'd1);
    check(data_out === '0, "R1 data in reset", data_out, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready === 1'b1, "R1 ready after reset", 64'(ready), 64'd1);
    check(data_out === '0, "R1 data after reset", data_out, 64'd0);

    for (int i = 0; i < 4; i++)
      for (int a = 0; a < 256; a++) begin
        sb_m[i][a] = mixv(i * 1000 + a + 7);
        tbl_write(i, a, sb_m[i][a]);
      end
    for (int k = 0; k < 18; k++) begin
      pk_m[k] = mixv(9000 + k);
      tbl_write(4, k, pk_m[k]);
    end

    // R2 R4: encryption over several patterns
    run_op(64'h0, 1'b1, 2, model(64'h0, 1'b1));
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2, model(64'hFFFF_FFFF_FFFF_FFFF, 1'b1));
    run_op(64'h0123_4567_89AB_CDEF, 1'b1, 2, model(64'h0123_4567_89AB_CDEF, 1'b1));
    run_op(64'hA5A5_5A5A_F00F_0FF0, 1'b1, 2, model(64'hA5A5_5A5A_F00F_0FF0, 1'b1));
    wait_done();

    // R3: decryption restores plaintext
    ct = model(64'h0123_4567_89AB_CDEF, 1'b1);
    run_op(ct, 1'b0, 3, 64'h0123_4567_89AB_CDEF);
    ct = model(64'hA5A5_5A5A_F00F_0FF0, 1'b1);
    run_op(ct, 1'b0, 3, 64'hA5A5_5A5A_F00F_0FF0);
    run_op(64'hFEDC_BA98_7654_3210, 1'b0, 3, model(64'hFEDC_BA98_7654_3210, 1'b0));
    wait_done();

    // R6: start pulses and input changes while busy are ignored
    pt = 64'h1111_2222_3333_4444;
    run_op(pt, 1'b1, 6, model(pt, 1'b1));
    repeat (3) @(negedge clk);
    for (int c = 0; c < 6; c++) begin
      new_data = 1'b1; data_in = ~pt ^ 64'(c); encrypt = 1'b0;
      @(negedge clk);
    end
    new_data = 1'b0;
    wait_done();
    repeat (4) @(negedge clk);
    check(ready === 1'b1, "R6 no second start", 64'(ready), 64'd1);
    check(data_out === model(pt, 1'b1), "R6 result kept", data_out, model(pt, 1'b1));

    // R8: writes while busy and out-of-range subkey writes are ignored
    pt = 64'h5555_AAAA_0F0F_F0F0;
    run_op(pt, 1'b1, 8, model(pt, 1'b1));
    repeat (4) @(negedge clk);
    tbl_write(1, 8'h3C, 32'hDEAD_BEEF);
    tbl_write(4, 5, 32'hBAD0_0BAD);
    wait_done();
    tbl_write(4, 8'h22, 32'hCAFE_F00D);
    tbl_write(4, 8'h12, 32'h1234_5678);
    tbl_write(5, 0, 32'h0BAD_CAFE);
    pt = 64'h7777_0000_1357_9BDF;
    run_op(pt, 1'b1, 8, model(pt, 1'b1));
    wait_done();

    // R8: idle writes take effect in the chosen memory
    pk_m[2] = 32'h0F1E_2D3C;
    tbl_write(4, 2, pk_m[2]);
    sb_m[3][8'h80] = 32'h8070_6050;
    tbl_write(3, 8'h80, sb_m[3][8'h80]);
    run_op(pt, 1'b1, 8, model(pt, 1'b1));
    ct = model(pt, 1'b1);
    run_op(ct, 1'b0, 3, pt);
    wait_done();

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule